// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside a processor core's execute stage and decides, on any cycle with a pending event, whether the core enters a synchronous exception handler or an external interrupt handler. It arbitrates between the two sources and applies the rules of the status register's block bit. It then writes the saved copies of the status register, the program counter and the stack register R15. It records the event code and produces the updated status register and the handler address. The whole entry happens in one clock edge.

The core presents the pending exception code, the interrupt request, the sleep and delay-slot flags, and the current architectural registers. The block presents the current interrupt mask level to an external interrupt controller and receives back either a vector or an indication that nothing above that level is pending. An `entry` pulse marks the cycle in which the new register values are valid. The sequencer does not evaluate events in the cycle after an entry, which gives the core one cycle to load the new state.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every output register (`entry`, `dslot_clr`, `spc`, `ssr`, `sgr`, `expevt`, `intevt`, `sr_out`, `pc_out`) reads zero.
- R2: When `exc_pend` is high the exception is entered even if `irq_req` is also high. `expevt` takes the exception code and `intevt` keeps its previous value.
- R3: With the block bit (`sr_in` bit 28) set, a pending exception code other than 0x1E0 is entered as code 0x000. Code 0x1E0 is entered unchanged.
- R4: With the block bit set and `in_sleep` low, an interrupt request causes no entry and leaves all outputs unchanged. With `in_sleep` high the interrupt is entered.
- R5: `irq_level` always equals `sr_in[7:4]`. When `intc_none` is high, an interrupt request with no exception pending causes no entry.
- R6: On entry `ssr` takes `sr_in`, `sgr` takes `r15_in`, and `sr_out` takes `sr_in` with bits 28, 29 and 30 set.
- R7: When `in_dslot` is high at entry, the saved PC base is `pc_in - 2` and `dslot_clr` pulses together with `entry`. Otherwise `dslot_clr` stays low.
- R8: Entry with code 0x000 sets `pc_out` to 0xA0000000 and forces `sr_out[7:4]` to 0xF.
- R9: An interrupt entry loads `intevt` with `intc_vec`, sets `pc_out` to `vbr_in + 0x600`, and leaves `expevt` unchanged.
- R10: Exception codes 0x040 and 0x060 jump to `vbr_in + 0x400`. All other nonzero codes, including 0x1E0 and 0x160, jump to `vbr_in + 0x100`. `expevt` takes the entered code.
- R11: For code 0x160 the saved PC is advanced by 2 after any delay-slot rewind, so `spc` equals `pc_in + 2`, or `pc_in` in a delay slot. For other codes `spc` is the rewound base.
- R12: `entry` is a one-cycle pulse registered on the clock edge after the event. Inputs in the cycle that shows `entry` high are not evaluated, so two consecutive cycles never both show `entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_pend | input | 1 | A synchronous exception is pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | External interrupt request |
| in_sleep | input | 1 | Core is in sleep state |
| in_dslot | input | 1 | Current instruction sits in a branch delay slot |
| sr_in | input | 32 | Current status register |
| vbr_in | input | 32 | Vector base register |
| pc_in | input | 32 | Current program counter |
| r15_in | input | 32 | Current value of R15 |
| irq_level | output | 4 | Interrupt mask level sent to the interrupt controller |
| intc_vec | input | 12 | Vector returned by the interrupt controller |
| intc_none | input | 1 | Controller has nothing pending above the mask level |
| entry | output | 1 | One-cycle pulse: the new register values are valid |
| dslot_clr | output | 1 | Delay-slot flags must be cleared |
| spc | output | 32 | Saved program counter |
| ssr | output | 32 | Saved status register |
| sgr | output | 32 | Saved R15 |
| expevt | output | 12 | Exception event code |
| intevt | output | 12 | Interrupt event code |
| sr_out | output | 32 | Updated status register |
| pc_out | output | 32 | Handler address |

## Verification
The assertions assume that the core holds `sr_in`, `pc_in`, `vbr_in` and `r15_in` stable through the cycle in which an event is sampled. They also assume that `intc_vec` and `intc_none` are settled against the `irq_level` that the block presents in that same cycle. The stimulus changes every input only between clock edges. It derives the controller response from the `sr_in` value it has just driven, and it keeps the event inputs unchanged for the whole sampled cycle. In particular, it holds `exc_pend` high across an entry to show that the following cycle is not evaluated.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int CODE_W = 12;

  localparam logic [CODE_W-1:0] CODE_RESET  = 12'h000;
  localparam logic [CODE_W-1:0] CODE_NOMASK = 12'h1E0;
  localparam logic [CODE_W-1:0] CODE_TLB_RD = 12'h040;
  localparam logic [CODE_W-1:0] CODE_TLB_WR = 12'h060;
  localparam logic [CODE_W-1:0] CODE_TRAP   = 12'h160;

  localparam int SR_BL_BIT = 28;
  localparam int SR_RB_BIT = 29;
  localparam int SR_MD_BIT = 30;
  localparam int SR_IM_LO  = 4;

  typedef enum logic [1:0] {EV_NONE, EV_EXC, EV_IRQ} ev_kind_e;

  // Code that is actually entered once the block bit is applied.
  function automatic logic [CODE_W-1:0] entered_code(input logic blk,
                                                     input logic [CODE_W-1:0] raw);
    return (blk && raw != CODE_NOMASK) ? CODE_RESET : raw;
  endfunction

  // Handler offset from the vector base for each class of event.
  function automatic logic [11:0] handler_offset(input ev_kind_e kind,
                                                 input logic [CODE_W-1:0] code);
    if (kind == EV_IRQ) return 12'h600;
    if (code == CODE_TLB_RD || code == CODE_TLB_WR) return 12'h400;
    return 12'h100;
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic              busy,
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              in_sleep,
  input  logic              blk,
  input  logic              intc_none,
  output ev_kind_e          kind,
  output logic [CODE_W-1:0] code
);

  logic irq_ok;
  assign irq_ok = irq_req && (!blk || in_sleep) && !intc_none;

  always_comb begin
    kind = EV_NONE;
    code = '0;
    if (!busy) begin
      if (exc_pend) begin
        kind = EV_EXC;
        code = entered_code(blk, exc_code);
      end else if (irq_ok) begin
        kind = EV_IRQ;
      end
    end
  end

endmodule

// File: rtl/exc_target.sv
module exc_target
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ev_kind_e          kind,
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic              in_dslot,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   new_spc
);

  localparam logic [XLEN-1:0] RESET_PC = XLEN'(32'hA000_0000);
  localparam logic [XLEN-1:0] STEP     = XLEN'(2);

  logic is_reset, is_trap;
  logic [XLEN-1:0] base_pc;

  assign is_reset = (kind == EV_EXC) && (code == CODE_RESET);
  assign is_trap  = (kind == EV_EXC) && (code == CODE_TRAP);
  assign base_pc  = in_dslot ? pc_in - STEP : pc_in;

  always_comb begin
    new_sr = sr_in;
    new_sr[SR_BL_BIT] = 1'b1;
    new_sr[SR_RB_BIT] = 1'b1;
    new_sr[SR_MD_BIT] = 1'b1;
    if (is_reset) new_sr[SR_IM_LO+3:SR_IM_LO] = 4'hF;
  end

  assign new_spc = is_trap ? base_pc + STEP : base_pc;
  assign new_pc  = is_reset ? RESET_PC
                            : vbr_in + XLEN'(handler_offset(kind, code));

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              irq_req,
  input  logic              in_sleep,
  input  logic              in_dslot,
  input  logic [XLEN-1:0]   sr_in,
  input  logic [XLEN-1:0]   vbr_in,
  input  logic [XLEN-1:0]   pc_in,
  input  logic [XLEN-1:0]   r15_in,
  output logic [3:0]        irq_level,
  input  logic [CODE_W-1:0] intc_vec,
  input  logic              intc_none,
  output logic              entry,
  output logic              dslot_clr,
  output logic [XLEN-1:0]   spc,
  output logic [XLEN-1:0]   ssr,
  output logic [XLEN-1:0]   sgr,
  output logic [CODE_W-1:0] expevt,
  output logic [CODE_W-1:0] intevt,
  output logic [XLEN-1:0]   sr_out,
  output logic [XLEN-1:0]   pc_out
);

  ev_kind_e          ev_kind;
  logic [CODE_W-1:0] ev_code;
  logic [XLEN-1:0]   nxt_sr, nxt_pc, nxt_spc;
  logic              go;

  assign irq_level = sr_in[SR_IM_LO+3:SR_IM_LO];

  exc_arbiter u_arb (
    .busy     (entry),
    .exc_pend (exc_pend),
    .exc_code (exc_code),
    .irq_req  (irq_req),
    .in_sleep (in_sleep),
    .blk      (sr_in[SR_BL_BIT]),
    .intc_none(intc_none),
    .kind     (ev_kind),
    .code     (ev_code)
  );

  exc_target #(.XLEN(XLEN)) u_tgt (
    .kind    (ev_kind),
    .code    (ev_code),
    .sr_in   (sr_in),
    .vbr_in  (vbr_in),
    .pc_in   (pc_in),
    .in_dslot(in_dslot),
    .new_sr  (nxt_sr),
    .new_pc  (nxt_pc),
    .new_spc (nxt_spc)
  );

  assign go = (ev_kind != EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry     <= 1'b0;
      dslot_clr <= 1'b0;
      spc       <= '0;
      ssr       <= '0;
      sgr       <= '0;
      expevt    <= '0;
      intevt    <= '0;
      sr_out    <= '0;
      pc_out    <= '0;
    end else begin
      entry     <= go;
      dslot_clr <= go && in_dslot;
      if (go) begin
        spc    <= nxt_spc;
        ssr    <= sr_in;
        sgr    <= r15_in;
        sr_out <= nxt_sr;
        pc_out <= nxt_pc;
        if (ev_kind == EV_EXC) expevt <= ev_code;
        if (ev_kind == EV_IRQ) intevt <= intc_vec;
      end
    end
  end

  // R2
  exc_beats_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && exc_pend && irq_req) |=> (entry && $stable(intevt)));

  // R4
  blocked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_pend && sr_in[SR_BL_BIT] && !in_sleep) |=> !entry);

  // R5
  none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_pend && intc_none) |=> !entry);

  // R6
  saved_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && go) |=> (ssr == $past(sr_in) && sgr == $past(r15_in)
                        && sr_out[SR_MD_BIT] && sr_out[SR_RB_BIT] && sr_out[SR_BL_BIT]));

  // R7
  dslot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dslot_clr |-> entry);

  // R8
  reset_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry && exc_pend && sr_in[SR_BL_BIT] && exc_code != CODE_NOMASK)
    |=> (pc_out == XLEN'(32'hA000_0000) && sr_out[SR_IM_LO+3:SR_IM_LO] == 4'hF));

  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry |=> !entry);

endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_pend = 0, irq_req = 0, in_sleep = 0, in_dslot = 0, intc_none = 0;
  logic [11:0] exc_code = '0, intc_vec = '0;
  logic [31:0] sr_in = '0, vbr_in = '0, pc_in = '0, r15_in = '0;
  logic [3:0]  irq_level;
  logic        entry, dslot_clr;
  logic [31:0] spc, ssr, sgr, sr_out, pc_out;
  logic [11:0] expevt, intevt;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";

  // Reference state
  logic        m_entry = 0, m_dclr = 0;
  logic [31:0] m_spc = 0, m_ssr = 0, m_sgr = 0, m_sr = 0, m_pc = 0;
  logic [11:0] m_exp = 0, m_int = 0;

  always #4 clk = ~clk;

  exc_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .exc_pend(exc_pend), .exc_code(exc_code),
    .irq_req(irq_req), .in_sleep(in_sleep), .in_dslot(in_dslot),
    .sr_in(sr_in), .vbr_in(vbr_in), .pc_in(pc_in), .r15_in(r15_in),
    .irq_level(irq_level), .intc_vec(intc_vec), .intc_none(intc_none),
    .entry(entry), .dslot_clr(dslot_clr), .spc(spc), .ssr(ssr), .sgr(sgr),
    .expevt(expevt), .intevt(intevt), .sr_out(sr_out), .pc_out(pc_out)
  );

  task automatic check_all();
    logic [185:0] act, exp;
    act = {entry, dslot_clr, spc, ssr, sgr, expevt, intevt, sr_out, pc_out};
    exp = {m_entry, m_dclr, m_spc, m_ssr, m_sgr, m_exp, m_int, m_sr, m_pc};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outputs actual=%h expected=%h", cur_req, act, exp);
    end
    checks++;
    if (irq_level !== sr_in[7:4]) begin
      errors++;
      $display("FAIL R5 irq_level actual=%h expected=%h", irq_level, sr_in[7:4]);
    end
  endtask

  // One clock: predict from the present inputs, step, compare.
  task automatic cycle();
    int     pend;
    bit     take_exc, take_irq, blk;
    int     code;
    logic [31:0] base, nsr;
    blk  = sr_in[28];
    pend = exc_pend ? int'(exc_code) : -1;
    take_exc = !m_entry && (pend >= 0);
    take_irq = !m_entry && (pend < 0) && irq_req && (in_sleep || !blk) && !intc_none;
    code = (take_exc && blk && pend != 'h1E0) ? 0 : pend;
    @(posedge clk);
    #2;
    m_entry = take_exc || take_irq;
    m_dclr  = m_entry && in_dslot;
    if (m_entry) begin
      base  = in_dslot ? pc_in - 32'd2 : pc_in;
      m_ssr = sr_in;
      m_sgr = r15_in;
      nsr   = sr_in | 32'h7000_0000;
      if (take_irq) begin
        m_int = intc_vec;
        m_pc  = vbr_in + 32'h600;
        m_spc = base;
      end else begin
        m_exp = 12'(code);
        m_spc = (code == 'h160) ? base + 32'd2 : base;
        if (code == 0) begin
          m_pc = 32'hA000_0000;
          nsr  = (nsr & ~32'hF0) | 32'hF0;
        end else if (code == 'h40 || code == 'h60) m_pc = vbr_in + 32'h400;
        else m_pc = vbr_in + 32'h100;
      end
      m_sr = nsr;
    end
    check_all();
  endtask

  task automatic quiet();
    exc_pend = 0; irq_req = 0; in_sleep = 0; in_dslot = 0; intc_none = 0;
  endtask

  task automatic exc_ev(string req, logic [31:0] sr, logic [11:0] c, logic ds);
    cur_req = req;
    sr_in = sr; exc_pend = 1; exc_code = c; in_dslot = ds;
    cycle();
    quiet();
    cycle();
  endtask

  task automatic irq_ev(string req, logic [31:0] sr, logic [11:0] v,
                        logic slp, logic none);
    cur_req = req;
    sr_in = sr; irq_req = 1; in_sleep = slp; intc_vec = v; intc_none = none;
    cycle();
    quiet();
    cycle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vbr_in = 32'h8C00_0000; pc_in = 32'h0C00_1000; r15_in = 32'h0CFF_FFF0;
    repeat (2) @(posedge clk);
    #2 rst_n = 1'b1;
    cur_req = "R1";
    cycle();
    cycle();
    // R10 general and TLB-miss class vectors
    exc_ev("R10", 32'h0000_0030, 12'h0E0, 0);
    exc_ev("R10", 32'h0000_0030, 12'h040, 0);
    pc_in = 32'h0C00_2222;
    exc_ev("R10", 32'h0000_0080, 12'h060, 0);
    // R2 exception beats interrupt
    cur_req = "R2";
    sr_in = 32'h0000_0010; exc_pend = 1; exc_code = 12'h0A0; irq_req = 1; intc_vec = 12'h320;
    cycle(); quiet(); cycle();
    // R3 block bit masks to reset, 0x1E0 passes
    exc_ev("R3", 32'h1000_0020, 12'h0A0, 0);
    exc_ev("R3", 32'h1000_0020, 12'h1E0, 0);
    // R8 explicit reset code, mask forced
    exc_ev("R8", 32'h0000_0050, 12'h000, 0);
    // R9 interrupt entry
    vbr_in = 32'h8000_1000; r15_in = 32'h1234_5678;
    irq_ev("R9", 32'h0000_0060, 12'h2A0, 0, 0);
    // R4 blocked then sleeping
    irq_ev("R4", 32'h1000_0000, 12'h200, 0, 0);
    irq_ev("R4", 32'h1000_0000, 12'h200, 1, 0);
    // R5 controller reports nothing
    irq_ev("R5", 32'h0000_00E0, 12'h3C0, 0, 1);
    // R6 saved state with odd SR
    r15_in = 32'hDEAD_BEEF;
    exc_ev("R6", 32'h0000_83F3, 12'h180, 0);
    // R7 delay-slot rewind
    pc_in = 32'h0C00_4000;
    exc_ev("R7", 32'h0000_0000, 12'h0E0, 1);
    // R11 trap, with and without delay slot
    exc_ev("R11", 32'h0000_0000, 12'h160, 0);
    exc_ev("R11", 32'h0000_0000, 12'h160, 1);
    // R12 held request: pulse, gap, pulse
    cur_req = "R12";
    sr_in = 32'h0; exc_pend = 1; exc_code = 12'h100;
    cycle(); cycle(); cycle(); cycle();
    quiet(); cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule